// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures the period of a fan's tachometer signal. A 16-bit counter
counts downward from its preload value on ticks produced by dividing the
peripheral clock by a programmable 8-bit prescaler plus one. The tach input is
brought into the clock domain through a synchroniser, and only its falling
edges act. The first falling edge after a start reloads the counter to 0xFFFF.
The second falling edge copies the counter into the capture register and raises
the capture pending flag. The captured value is therefore 0xFFFF minus the
number of ticks in one tach period. A fan produces two tach pulses per
revolution, so driver software converts the result to a speed.

A compare register bounds each measurement. If the counter steps onto the
compare value before a capture happens, a timeout pending flag is raised instead
and nothing is captured. After either outcome the counter freezes until software
writes it again, so each start yields one measurement. Software reaches the
registers through a simple halfword bus with per-byte write enables. Six pending
bits are cleared by writing ones, and the interrupt output is high while any
pending bit is also enabled.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset the counter, capture and compare registers read 0xFFFF, the prescaler, run bit, pending and enable registers read 0, and `irq` is low.
- R2: Halfword index (byte offset / 2) selects the register: 0 counter, 1 capture, 4 prescaler, 5 run control (bit 0), 7 pending, 8 clear, 9 enable, 10 compare. `bus_be[0]` writes bits 7:0 and `bus_be[1]` writes bits 15:8. The byte-wide registers take only the low lane. Every other index reads 0 and ignores writes.
- R3: While run bit 0 is 0 the counter holds its value. Once it is set, the counter steps down.
- R4: With prescaler value P, the counter steps once every P+1 clock cycles, with the first step P+1 cycles after the run bit is set.
- R5: For two tach falling edges D clock cycles apart, the capture register receives 0xFFFF − floor(D/(P+1)) and pending bit 0 is set.
- R6: When a counter step lands on the compare value before a capture, pending bit 4 is set, the capture register keeps its value, and the counter stays at the compare value.
- R7: After a capture or a timeout the counter holds until software writes it. A counter write restarts the measurement, waiting again for a first falling edge.
- R8: Writing ones to the clear register clears the matching pending bits. Writes to the pending register have no effect.
- R9: `irq` is high exactly while some pending bit and its enable bit are both 1.
- R10: Tach edges while the run bit is 0 have no effect on the counter, capture or pending bits. Rising edges never trigger a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_hw_addr | input | 4 | Halfword register index |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte lane write enables |
| bus_rdata | output | 16 | Read data for the addressed register |
| tach_in | input | 1 | Asynchronous tachometer input |
| irq | output | 1 | Interrupt, any enabled pending bit |

## Verification
The capture path is swept over a grid of prescaler values 0, 1, 2 and 5 and tach periods of 4, 7, 12 and 30 cycles. These pairs separate exact multiples of the tick length from remainders, which exposes any error in floor rounding or in the off-by-one between the first edge and the first tick. A no-edge run with a compare value close to the start shows that timeout and capture are exclusive and that the counter freezes at the compare value. A reload after the freeze, with its exact tick count, shows the restart. Edges applied while stopped, a write to the pending register, and a capture with all enables at zero each check that those inputs leave the outputs unchanged.

// File: rtl/tach_pkg.sv
`timescale 1ns/1ps
package tach_pkg;

    localparam int CNT_W        = 16;
    localparam int PEND_W       = 6;
    localparam int PEND_CAP_BIT = 0;
    localparam int PEND_TMO_BIT = 4;

    // Halfword register index as decoded by software drivers
    typedef enum logic [3:0] {
        RG_COUNT   = 4'd0,
        RG_CAPT    = 4'd1,
        RG_PRESC   = 4'd4,
        RG_RUN     = 4'd5,
        RG_PEND    = 4'd7,
        RG_CLEAR   = 4'd8,
        RG_ENABLE  = 4'd9,
        RG_LIMIT   = 4'd10
    } reg_idx_e;

    typedef enum logic {
        PH_WAIT_FIRST = 1'b0,
        PH_TIMING     = 1'b1
    } meas_phase_e;

    function automatic logic [CNT_W-1:0] lane_merge(
        input logic [CNT_W-1:0] old_v,
        input logic [CNT_W-1:0] new_v,
        input logic [1:0]       be
    );
        logic [CNT_W-1:0] r;
        r = old_v;
        if (be[0]) r[7:0]  = new_v[7:0];
        if (be[1]) r[15:8] = new_v[15:8];
        return r;
    endfunction

endpackage

// File: rtl/tach_edge_sync.sv
`timescale 1ns/1ps
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    // Idle level of a tach line is high; reset there to avoid a false edge
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            last_q  <= 1'b1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign fall = last_q & ~shift_q[STAGES-1];
endmodule

// File: rtl/tach_prescaler.sv
`timescale 1ns/1ps
module tach_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pre_q;
    logic             wrap;

    assign wrap = (pre_q >= div);
    assign tick = en & wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= wrap ? '0 : pre_q + PSC_W'(1);
        end
    end
endmodule

// File: rtl/tach_meas_core.sv
`timescale 1ns/1ps
module tach_meas_core
    import tach_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    input  logic [PSC_W-1:0] div,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt,
    output logic             done,
    output logic             cap_evt,
    output logic [CNT_W-1:0] cap_val,
    output logic             tmo_evt
);
    meas_phase_e      phase_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active, arm, tick;
    logic [CNT_W-1:0] dec, stepped;

    assign active  = run & ~done_q & ~load;
    assign arm     = active & fall & (phase_q == PH_WAIT_FIRST);
    assign cap_evt = active & fall & (phase_q == PH_TIMING);
    assign dec     = cnt_q - CNT_W'(1);
    assign stepped = tick ? dec : cnt_q;
    // capture outranks a coincident timeout step
    assign tmo_evt = active & tick & (dec == limit) & ~fall;
    assign cap_val = stepped;
    assign cnt     = cnt_q;
    assign done    = done_q;

    tach_prescaler #(.PSC_W(PSC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (~active | arm),
        .en   (active),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            phase_q <= PH_WAIT_FIRST;
            done_q  <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            phase_q <= PH_WAIT_FIRST;
            done_q  <= 1'b0;
        end else if (arm) begin
            cnt_q   <= '1;
            phase_q <= PH_TIMING;
        end else if (cap_evt) begin
            cnt_q   <= stepped;
            done_q  <= 1'b1;
        end else if (active && tick) begin
            cnt_q   <= dec;
            if (tmo_evt) done_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tach_capture_timer.sv
`timescale 1ns/1ps
module tach_capture_timer
    import tach_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_hw_addr,
    input  logic [15:0] bus_wdata,
    input  logic [1:0]  bus_be,
    output logic [15:0] bus_rdata,
    input  logic        tach_in,
    output logic        irq
);
    reg_idx_e          idx;
    logic [CNT_W-1:0]  cap_q, cmp_q, cnt_val, cap_val;
    logic [PSC_W-1:0]  psc_q;
    logic              ckc_q;
    logic [PEND_W-1:0] pend_q, ien_q, clr_bits, set_bits;
    logic              wr_cnt, wr_cap, wr_cmp, wr_lo;
    logic              fall, cap_evt, tmo_evt, core_done;

    assign idx    = reg_idx_e'(bus_hw_addr);
    assign wr_cnt = bus_wr & (idx == RG_COUNT) & (|bus_be);
    assign wr_cap = bus_wr & (idx == RG_CAPT)  & (|bus_be);
    assign wr_cmp = bus_wr & (idx == RG_LIMIT) & (|bus_be);
    assign wr_lo  = bus_wr & bus_be[0];
    assign clr_bits = (wr_lo && idx == RG_CLEAR) ? bus_wdata[PEND_W-1:0] : '0;

    always_comb begin
        set_bits               = '0;
        set_bits[PEND_CAP_BIT] = cap_evt;
        set_bits[PEND_TMO_BIT] = tmo_evt;
    end

    tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (tach_in),
        .fall (fall)
    );

    tach_meas_core #(.PSC_W(PSC_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (ckc_q),
        .load     (wr_cnt),
        .load_val (lane_merge(cnt_val, bus_wdata, bus_be)),
        .limit    (cmp_q),
        .div      (psc_q),
        .fall     (fall),
        .cnt      (cnt_val),
        .done     (core_done),
        .cap_evt  (cap_evt),
        .cap_val  (cap_val),
        .tmo_evt  (tmo_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '1;
            cmp_q  <= '1;
            psc_q  <= '0;
            ckc_q  <= 1'b0;
            pend_q <= '0;
            ien_q  <= '0;
        end else begin
            if (cap_evt)     cap_q <= cap_val;
            else if (wr_cap) cap_q <= lane_merge(cap_q, bus_wdata, bus_be);
            if (wr_cmp)      cmp_q <= lane_merge(cmp_q, bus_wdata, bus_be);
            if (wr_lo && idx == RG_PRESC)  psc_q <= bus_wdata[PSC_W-1:0];
            if (wr_lo && idx == RG_RUN)    ckc_q <= bus_wdata[0];
            if (wr_lo && idx == RG_ENABLE) ien_q <= bus_wdata[PEND_W-1:0];
            // a new event in the clearing cycle survives the clear
            pend_q <= (pend_q & ~clr_bits) | set_bits;
        end
    end

    always_comb begin
        case (idx)
            RG_COUNT:  bus_rdata = cnt_val;
            RG_CAPT:   bus_rdata = cap_q;
            RG_PRESC:  bus_rdata = 16'(psc_q);
            RG_RUN:    bus_rdata = {15'd0, ckc_q};
            RG_PEND:   bus_rdata = 16'(pend_q);
            RG_ENABLE: bus_rdata = 16'(ien_q);
            RG_LIMIT:  bus_rdata = cmp_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(pend_q & ien_q);
endmodule

// File: rtl/tach_capture_timer_chk.sv
`timescale 1ns/1ps
module tach_capture_timer_chk
    import tach_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_cnt,
    input logic              wr_cap,
    input logic              ckc_q,
    input logic              core_done,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  cap_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic              cap_evt,
    input logic              tmo_evt,
    input logic [PEND_W-1:0] clr_bits,
    input logic [PEND_W-1:0] set_bits,
    input logic [PEND_W-1:0] pend_q,
    input logic [PEND_W-1:0] ien_q,
    input logic              irq
);
    // R3: stopped counter holds
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!ckc_q && !wr_cnt) |=> $stable(cnt_val));

    // R7: finished measurement holds until reload
    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        (core_done && !wr_cnt) |=> $stable(cnt_val));

    // R5: capture register moves only on a capture or a write
    a_r5_capture_only_on_event: assert property (@(posedge clk) disable iff (rst)
        (!wr_cap && !cap_evt) |=> $stable(cap_q));

    // R6: counter sits on the compare value after a timeout
    a_r6_timeout_at_limit: assert property (@(posedge clk) disable iff (rst)
        (tmo_evt && !wr_cnt) |=> (cnt_val == $past(cmp_q)));

    // R6: timeout and capture never coincide
    a_r6_exclusive_events: assert property (@(posedge clk) disable iff (rst)
        !(cap_evt && tmo_evt));

    // R8: clearing all with no new event empties pending
    a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
        (clr_bits == '1 && set_bits == '0) |=> (pend_q == '0));

    // R9: interrupt needs an enable bit
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q != '0));
endmodule

bind tach_capture_timer tach_capture_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_cnt    (wr_cnt),
    .wr_cap    (wr_cap),
    .ckc_q     (ckc_q),
    .core_done (core_done),
    .cnt_val   (cnt_val),
    .cap_q     (cap_q),
    .cmp_q     (cmp_q),
    .cap_evt   (cap_evt),
    .tmo_evt   (tmo_evt),
    .clr_bits  (clr_bits),
    .set_bits  (set_bits),
    .pend_q    (pend_q),
    .ien_q     (ien_q),
    .irq       (irq)
);

// File: tb/tb_tach_capture_timer.sv
`timescale 1ns/1ps
module tb_tach_capture_timer;

    localparam logic [3:0] A_CNT = 4'd0, A_CAP = 4'd1, A_RSV = 4'd2,
                           A_PSC = 4'd4, A_RUN = 4'd5, A_PEND = 4'd7,
                           A_CLR = 4'd8, A_IEN = 4'd9, A_CMP = 4'd10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_hw_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic        tach_in = 1'b1;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    tach_capture_timer dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_hw_addr (bus_hw_addr),
        .bus_wdata   (bus_wdata),
        .bus_be      (bus_be),
        .bus_rdata   (bus_rdata),
        .tach_in     (tach_in),
        .irq         (irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_hw_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_hw_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tach_fall();
        @(negedge clk); tach_in = 1'b0;
        repeat (2) @(negedge clk);
        tach_in = 1'b1;
    endtask

    // two falls D cycles apart
    task automatic two_falls(input int d);
        @(negedge clk); tach_in = 1'b0;
        repeat (2) @(negedge clk);
        tach_in = 1'b1;
        repeat (d - 2) @(negedge clk);
        tach_in = 1'b0;
        repeat (2) @(negedge clk);
        tach_in = 1'b1;
    endtask

    task automatic setup_run(input int psc, input logic [15:0] cmp, input logic [5:0] ien);
        wr(A_RUN, 16'h0, 2'b01);
        wr(A_PSC, 16'(psc), 2'b01);
        wr(A_CMP, cmp, 2'b11);
        wr(A_CAP, 16'hFFFF, 2'b11);
        wr(A_CLR, 16'h3F, 2'b01);
        wr(A_IEN, 16'(ien), 2'b01);
        wr(A_CNT, 16'hFFFF, 2'b11);
        wr(A_RUN, 16'h1, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp;
        int pscs [4] = '{0, 1, 2, 5};
        int dlys [4] = '{4, 7, 12, 30};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CNT, v);  chk("R1 counter", v, 16'hFFFF);
        rd(A_CAP, v);  chk("R1 capture", v, 16'hFFFF);
        rd(A_CMP, v);  chk("R1 compare", v, 16'hFFFF);
        rd(A_PSC, v);  chk("R1 prescaler", v, 16'h0);
        rd(A_RUN, v);  chk("R1 run", v, 16'h0);
        rd(A_PEND, v); chk("R1 pending", v, 16'h0);
        rd(A_IEN, v);  chk("R1 enable", v, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);

        // R2 byte lanes and reserved index
        wr(A_CMP, 16'h11AB, 2'b01);
        rd(A_CMP, v); chk("R2 low lane", v, 16'hFFAB);
        wr(A_CMP, 16'hCD22, 2'b10);
        rd(A_CMP, v); chk("R2 high lane", v, 16'hCDAB);
        wr(A_RSV, 16'hFFFF, 2'b11);
        rd(A_RSV, v); chk("R2 reserved reads zero", v, 16'h0);
        wr(A_PSC, 16'h5A07, 2'b11);
        rd(A_PSC, v); chk("R2 byte register", v, 16'h0007);

        // R3 hold while stopped, R10 edges ignored while stopped
        wr(A_CMP, 16'h0000, 2'b11);
        wr(A_CNT, 16'h1000, 2'b11);
        tach_fall();
        tach_fall();
        repeat (15) @(negedge clk);
        rd(A_CNT, v);  chk("R3 stopped hold", v, 16'h1000);
        rd(A_PEND, v); chk("R10 stopped edges ignored", v, 16'h0);
        rd(A_CAP, v);  chk("R10 capture untouched", v, 16'hFFFF);

        // R4 tick rate: P=3, 20 cycles after start gives 5 steps
        wr(A_PSC, 16'd3, 2'b01);
        wr(A_RUN, 16'h1, 2'b01);
        repeat (20) @(negedge clk);
        rd(A_CNT, v); chk("R3 R4 run steps", v, 16'h1000 - 16'd5);

        // R5 sweep over prescaler and period
        foreach (pscs[i]) begin
            foreach (dlys[j]) begin
                setup_run(pscs[i], 16'h0000, 6'h3F);
                repeat (3) @(negedge clk);
                two_falls(dlys[j]);
                repeat (6) @(negedge clk);
                exp = 16'hFFFF - 16'(dlys[j] / (pscs[i] + 1));
                rd(A_CAP, v);  chk($sformatf("R5 capture p=%0d d=%0d", pscs[i], dlys[j]), v, exp);
                rd(A_PEND, v); chk("R5 capture pending", v, 16'h0001);
                rd(A_CNT, v);  chk("R7 counter frozen after capture", v, exp);
                chk("R9 irq on capture", {15'd0, irq}, 16'h1);
            end
        end

        // R8 pending is read-only, clear register clears
        wr(A_PEND, 16'h0000, 2'b11);
        rd(A_PEND, v); chk("R8 pending write ignored", v, 16'h0001);
        wr(A_CLR, 16'h0001, 2'b01);
        rd(A_PEND, v); chk("R8 clear", v, 16'h0);
        chk("R9 irq drops", {15'd0, irq}, 16'h0);

        // R9 masked: capture with no enables
        setup_run(0, 16'h0000, 6'h00);
        repeat (3) @(negedge clk);
        two_falls(9);
        repeat (6) @(negedge clk);
        rd(A_PEND, v); chk("R9 pending set while masked", v, 16'h0001);
        chk("R9 irq masked", {15'd0, irq}, 16'h0);

        // R6 timeout, R7 freeze and restart
        setup_run(0, 16'hFFFF - 16'd20, 6'h10);
        wr(A_RUN, 16'h0, 2'b01);
        wr(A_CAP, 16'h1234, 2'b11);
        wr(A_CNT, 16'hFFFF, 2'b11);
        wr(A_RUN, 16'h1, 2'b01);
        repeat (40) @(negedge clk);
        rd(A_PEND, v); chk("R6 timeout pending", v, 16'h0010);
        rd(A_CAP, v);  chk("R6 no capture", v, 16'h1234);
        rd(A_CNT, v);  chk("R6 counter at compare", v, 16'hFFEB);
        chk("R9 irq on timeout", {15'd0, irq}, 16'h1);
        two_falls(5);
        repeat (10) @(negedge clk);
        rd(A_CNT, v);  chk("R7 hold after timeout", v, 16'hFFEB);
        rd(A_CAP, v);  chk("R7 no capture after timeout", v, 16'h1234);
        wr(A_CNT, 16'hFFFF, 2'b11);
        repeat (5) @(negedge clk);
        rd(A_CNT, v);  chk("R7 restart after reload", v, 16'hFFFA);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule